// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock for an I2C master. It runs from the I2C peripheral clock and uses a clock-enable input to mark the peripheral cycles in which it may advance. A 16-bit timing word carries two 8-bit counts, one for the low part of the SCL period and one for the high part. The block pulls SCL low for the low part. It then releases the line and counts out the high part, but only while the sensed line is actually high. A slave that holds SCL low therefore stretches the clock.

The byte engine that shifts data follows four single-cycle strobes: the SCL falling edge, the rising edge, the middle of the low part (where SDA may change) and the middle of the high part (where SDA is sampled). The engine asks for clocks by holding the run request. When the request is dropped, the block finishes the period in progress and leaves SCL released.

Top module: `i2c_scl_gen`

## Requirements
- R1: During reset and after it, with no run request, `scl_drive_low` and all four strobes are 0.
- R2: The timing word holds the low count Lo in bits [7:0]. Each low part lasts exactly Lo+1 enabled cycles with `scl_drive_low` = 1.
- R3: The high count Hi is in bits [15:8]. An unstretched high part lasts Hi+2 enabled cycles, so one SCL period is Lo+Hi+3 enabled cycles. Lo=0x4F with Hi=0x4E gives 160 cycles, and Lo=0x13 with Hi=0x12 gives 40.
- R4: While SCL is released, the high-part count advances only in enabled cycles where `scl_in` is 1. Each cycle with `scl_in` = 0 lengthens the high part by one cycle. While SCL is released and sensed low, the block never starts driving low.
- R5: With `run_req` = 0 and SCL released, SCL stays released. A low part begins only when `run_req` = 1 and `scl_in` = 1. When `run_req` is removed during a period, the low part and the high part of that period complete, and then SCL stays released.
- R6: The timing word is sampled on entry to each low part. A change made later in the period does not alter the period in progress, and it takes effect from the next low part.
- R7: `stb_fall` is a one-cycle pulse in the first cycle with `scl_drive_low` = 1. `stb_rise` is a one-cycle pulse in the first cycle after the low part, when SCL is released. No other cycle carries either strobe.
- R8: Counting the cycle of `stb_fall` as index 0, `stb_mid_low` pulses at index (Lo+1)>>1. `stb_mid_high` pulses after (Hi+2)>>1 counted high cycles, which is index Lo+1+S+((Hi+2)>>1) where S is the number of stretch cycles.
- R9: In a cycle with `clk_en` = 0 the state does not advance and `scl_drive_low` keeps its value. With `clk_en` alternating on every cycle, each period takes 2*(Lo+Hi+3) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I2C peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Marks the cycles in which the generator advances |
| timing_cfg | input | 16 | High count [15:8], low count [7:0] |
| run_req | input | 1 | Request to keep producing SCL periods |
| scl_in | input | 1 | Sensed SCL line level, already synchronised |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| stb_fall | output | 1 | One-cycle pulse at the start of a low part |
| stb_rise | output | 1 | One-cycle pulse at the start of a high part |
| stb_mid_low | output | 1 | One-cycle pulse in the middle of the low part |
| stb_mid_high | output | 1 | One-cycle pulse in the middle of the counted high part |

## Verification
The assertions check on every cycle the rules that relate one cycle to the next. Each edge strobe must line up with a change in the drive. A released line that is sensed low, or a missing run request, must never lead to a new low drive, and a disabled cycle must leave the drive unchanged. The mid strobes must fall inside the correct half of the waveform. The exact lengths of the low and high parts, the mid-point positions, the extra cycles a stretch adds, the point at which a new timing word takes effect and the orderly stop after the request is dropped all depend on counted windows. Only the bench scenarios show these, by measuring whole periods against values computed from the two fields.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

    // width of one phase count field inside the timing word
    localparam int unsigned FIELD_W = 8;
    localparam int unsigned CFG_W   = 2 * FIELD_W;
    // phase counter needs one more bit: the high phase runs to Hi+1
    localparam int unsigned CNT_W   = FIELD_W + 1;

    typedef logic [CNT_W-1:0] cnt_t;

    // packed so that hi sits in the upper field and lo in the lower one
    typedef struct packed {
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] lo;
    } scl_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    // last counter value of the low phase (Lo+1 cycles: 0..Lo)
    function automatic cnt_t low_last(input logic [FIELD_W-1:0] lo);
        return cnt_t'(lo);
    endfunction

    // last counter value of the high phase (Hi+2 cycles: 0..Hi+1)
    function automatic cnt_t high_last(input logic [FIELD_W-1:0] hi);
        return cnt_t'(hi) + cnt_t'(1);
    endfunction

    // middle index of the low phase
    function automatic cnt_t low_mid(input logic [FIELD_W-1:0] lo);
        return (cnt_t'(lo) + cnt_t'(1)) >> 1;
    endfunction

    // middle index of the counted high phase (never zero)
    function automatic cnt_t high_mid(input logic [FIELD_W-1:0] hi);
        return (cnt_t'(hi) + cnt_t'(2)) >> 1;
    endfunction

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold
    import i2c_scl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  scl_cfg_t cfg_in,
    output scl_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import i2c_scl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       run_req,
    input  logic       scl_in,
    input  scl_cfg_t   cfg_held,
    output logic       load,
    output logic       adv_high,
    output scl_phase_e phase_q,
    output scl_phase_e nxt_phase,
    output cnt_t       nxt_cnt
);

    cnt_t cnt_q;

    always_comb begin
        nxt_phase = phase_q;
        nxt_cnt   = cnt_q;
        load      = 1'b0;
        adv_high  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (tick && run_req && scl_in) begin
                    nxt_phase = PH_LOW;
                    nxt_cnt   = '0;
                    load      = 1'b1;
                end
            end
            PH_LOW: begin
                if (tick) begin
                    if (cnt_q == low_last(cfg_held.lo)) begin
                        nxt_phase = PH_HIGH;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = cnt_q + cnt_t'(1);
                    end
                end
            end
            PH_HIGH: begin
                if (tick && scl_in) begin
                    adv_high = 1'b1;
                    if (cnt_q == high_last(cfg_held.hi)) begin
                        nxt_cnt = '0;
                        if (run_req) begin
                            nxt_phase = PH_LOW;
                            load      = 1'b1;
                        end else begin
                            nxt_phase = PH_IDLE;
                        end
                    end else begin
                        nxt_cnt = cnt_q + cnt_t'(1);
                    end
                end
            end
            default: begin
                nxt_phase = PH_IDLE;
                nxt_cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= nxt_phase;
            cnt_q   <= nxt_cnt;
        end
    end

endmodule

// File: rtl/scl_strobe_reg.sv
module scl_strobe_reg
    import i2c_scl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       adv_high,
    input  scl_phase_e phase_q,
    input  scl_phase_e nxt_phase,
    input  cnt_t       nxt_cnt,
    input  scl_cfg_t   cfg_eff,
    output logic       stb_fall,
    output logic       stb_rise,
    output logic       stb_mid_low,
    output logic       stb_mid_high
);

    logic fall_d, rise_d, mlow_d, mhigh_d;

    always_comb begin
        fall_d  = (nxt_phase == PH_LOW) && (phase_q != PH_LOW);
        rise_d  = (phase_q == PH_LOW) && (nxt_phase == PH_HIGH);
        mlow_d  = tick && (nxt_phase == PH_LOW) && (nxt_cnt == low_mid(cfg_eff.lo));
        mhigh_d = adv_high && (nxt_phase == PH_HIGH) && (nxt_cnt == high_mid(cfg_eff.hi));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_fall     <= 1'b0;
            stb_rise     <= 1'b0;
            stb_mid_low  <= 1'b0;
            stb_mid_high <= 1'b0;
        end else begin
            stb_fall     <= fall_d;
            stb_rise     <= rise_d;
            stb_mid_low  <= mlow_d;
            stb_mid_high <= mhigh_d;
        end
    end

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
    import i2c_scl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic [CFG_W-1:0] timing_cfg,
    input  logic             run_req,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             stb_fall,
    output logic             stb_rise,
    output logic             stb_mid_low,
    output logic             stb_mid_high
);

    scl_cfg_t   cfg_live;
    scl_cfg_t   cfg_held;
    scl_cfg_t   cfg_eff;
    logic       load;
    logic       adv_high;
    scl_phase_e phase_q;
    scl_phase_e nxt_phase;
    cnt_t       nxt_cnt;

    assign cfg_live = scl_cfg_t'(timing_cfg);
    // the word being latched this cycle governs the strobes of the new phase
    assign cfg_eff  = load ? cfg_live : cfg_held;

    scl_cfg_hold u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cfg_in (cfg_live),
        .cfg_q  (cfg_held)
    );

    scl_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (clk_en),
        .run_req   (run_req),
        .scl_in    (scl_in),
        .cfg_held  (cfg_held),
        .load      (load),
        .adv_high  (adv_high),
        .phase_q   (phase_q),
        .nxt_phase (nxt_phase),
        .nxt_cnt   (nxt_cnt)
    );

    scl_strobe_reg u_stb (
        .clk          (clk),
        .rst          (rst),
        .tick         (clk_en),
        .adv_high     (adv_high),
        .phase_q      (phase_q),
        .nxt_phase    (nxt_phase),
        .nxt_cnt      (nxt_cnt),
        .cfg_eff      (cfg_eff),
        .stb_fall     (stb_fall),
        .stb_rise     (stb_rise),
        .stb_mid_low  (stb_mid_low),
        .stb_mid_high (stb_mid_high)
    );

    assign scl_drive_low = (phase_q == PH_LOW);

endmodule

// File: rtl/scl_gen_checker.sv
module scl_gen_checker (
    input logic clk,
    input logic rst,
    input logic clk_en,
    input logic run_req,
    input logic scl_in,
    input logic scl_drive_low,
    input logic stb_fall,
    input logic stb_rise,
    input logic stb_mid_low,
    input logic stb_mid_high
);

    // R1: first cycle after reset shows everything quiet
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!scl_drive_low && !stb_fall && !stb_rise && !stb_mid_low && !stb_mid_high));

    // R7: falling strobe only in the first driven-low cycle
    assert_fall_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        stb_fall |-> (scl_drive_low && !$past(scl_drive_low)));

    // R7: rising strobe only in the first released cycle after a low part
    assert_rise_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        stb_rise |-> (!scl_drive_low && $past(scl_drive_low)));

    // R7: every start of low drive carries the falling strobe
    assert_fall_present_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_drive_low) |-> stb_fall);

    // R4: a released line held low by another device is never followed by our low drive
    assert_stretch_respected_R4: assert property (@(posedge clk) disable iff (rst)
        (!scl_drive_low && !scl_in) |=> !scl_drive_low);

    // R5: without a request a released line stays released
    assert_no_start_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!run_req && !scl_drive_low) |=> !scl_drive_low);

    // R9: a disabled cycle does not move the drive
    assert_hold_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(scl_drive_low));

    // R8: mid strobes sit inside their own half of the waveform
    assert_mid_low_inside_R8: assert property (@(posedge clk) disable iff (rst)
        stb_mid_low |-> scl_drive_low);
    assert_mid_high_inside_R8: assert property (@(posedge clk) disable iff (rst)
        stb_mid_high |-> !scl_drive_low);
    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb_fall, stb_rise, stb_mid_high}));

endmodule

bind i2c_scl_gen scl_gen_checker u_scl_chk (
    .clk           (clk),
    .rst           (rst),
    .clk_en        (clk_en),
    .run_req       (run_req),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .stb_fall      (stb_fall),
    .stb_rise      (stb_rise),
    .stb_mid_low   (stb_mid_low),
    .stb_mid_high  (stb_mid_high)
);

// File: tb/tb_i2c_scl_gen.sv
module tb_i2c_scl_gen;

    localparam int NVEC = 6;
    localparam logic [15:0] VEC_CFG [NVEC] = '{16'h4E4F, 16'h1213, 16'h0000, 16'hFFFF, 16'h0001, 16'h0905};
    localparam int VEC_PERIOD [NVEC] = '{160, 40, 3, 513, 4, 17};
    localparam int WATCHDOG_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b1;
    logic [15:0] timing_cfg = 16'h0000;
    logic        run_req = 1'b0;
    logic        slave_hold = 1'b0;
    logic        scl_in;
    logic        scl_drive_low, stb_fall, stb_rise, stb_mid_low, stb_mid_high;

    logic ce_alt = 1'b0;
    logic ce_off = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    // wired SCL line: low when driven by the block or held by a slave
    assign scl_in = ~(scl_drive_low | slave_hold);

    // clock-enable pattern, updated a quarter period after the rising edge
    always @(posedge clk) begin
        #5;
        if (ce_off)      clk_en = 1'b0;
        else if (ce_alt) clk_en = ~clk_en;
        else             clk_en = 1'b1;
    end

    i2c_scl_gen dut (
        .clk           (clk),
        .rst           (rst),
        .clk_en        (clk_en),
        .timing_cfg    (timing_cfg),
        .run_req       (run_req),
        .scl_in        (scl_in),
        .scl_drive_low (scl_drive_low),
        .stb_fall      (stb_fall),
        .stb_rise      (stb_rise),
        .stb_mid_low   (stb_mid_low),
        .stb_mid_high  (stb_mid_high)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Measures one SCL period starting at a sampled falling strobe; call at a negedge.
    task automatic measure(input int stretch, output int low_n, output int high_n,
                           output int ml_i, output int mh_i, output int rise_i, output int per);
        int k;
        int left;
        low_n = 0; high_n = 0; ml_i = -1; mh_i = -1; rise_i = -1; left = 0;
        while (stb_fall !== 1'b1) @(negedge clk);
        k = 0;
        do begin
            if (scl_drive_low) low_n++; else high_n++;
            if (stb_mid_low)  ml_i = k;
            if (stb_mid_high) mh_i = k;
            if (stb_rise) begin
                rise_i = k;
                if (stretch > 0) begin
                    slave_hold = 1'b1;
                    left = stretch;
                end
            end else if (left > 0) begin
                left--;
                if (left == 0) slave_hold = 1'b0;
            end
            k++;
            @(negedge clk);
        end while (stb_fall !== 1'b1);
        per = k;
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYC, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lo_n, hi_n, mli, mhi, ri, per;
        int lo, hi, cnt, bad;

        // ---- R1: reset state ----
        repeat (3) @(negedge clk);
        check(scl_drive_low == 1'b0 && stb_fall == 1'b0, "R1 drive in reset", scl_drive_low, 0);
        rst = 1'b0;
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (scl_drive_low || stb_fall || stb_rise || stb_mid_low || stb_mid_high) bad++;
        end
        check(bad == 0, "R1 quiet after reset", bad, 0);

        // ---- table of timing words ----
        run_req = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            timing_cfg = VEC_CFG[v];
            lo = int'(VEC_CFG[v][7:0]);
            hi = int'(VEC_CFG[v][15:8]);
            @(negedge clk);
            measure(0, lo_n, hi_n, mli, mhi, ri, per);   // period may still use the old word
            measure(0, lo_n, hi_n, mli, mhi, ri, per);
            check(lo_n == lo + 1, "R2 low length", lo_n, lo + 1);
            check(hi_n == hi + 2, "R3 high length", hi_n, hi + 2);
            check(per == VEC_PERIOD[v], "R3 period", per, VEC_PERIOD[v]);
            check(ri == lo + 1, "R7 rise position", ri, lo + 1);
            check(mli == (lo + 1) / 2, "R8 mid low position", mli, (lo + 1) / 2);
            check(mhi == lo + 1 + (hi + 2) / 2, "R8 mid high position", mhi, lo + 1 + (hi + 2) / 2);
        end

        // ---- R4: clock stretch of 4 cycles, word 0x0905 still active ----
        measure(4, lo_n, hi_n, mli, mhi, ri, per);
        check(hi_n == 9 + 2 + 4, "R4 stretched high", hi_n, 15);
        check(per == 21, "R4 stretched period", per, 21);
        check(mhi == 6 + 4 + 5, "R8 mid high after stretch", mhi, 15);

        // ---- R6: new word during high part applies from next low part ----
        while (stb_rise !== 1'b1) @(negedge clk);
        timing_cfg = 16'h0302;
        cnt = 0;
        do begin
            cnt++;
            @(negedge clk);
        end while (stb_fall !== 1'b1);
        check(cnt == 11, "R6 current high keeps old word", cnt, 11);
        measure(0, lo_n, hi_n, mli, mhi, ri, per);
        check(lo_n == 3 && hi_n == 5, "R6 next period uses new word", lo_n * 100 + hi_n, 305);

        // ---- R5: drop request at start of a low part ----
        run_req = 1'b0;
        lo_n = 0; cnt = 0; ri = 0;
        for (int i = 0; i < 300; i++) begin
            if (scl_drive_low) lo_n++;
            if (stb_rise) ri++;
            @(negedge clk);
            if (stb_fall) cnt++;
        end
        check(lo_n == 3, "R5 low part completes", lo_n, 3);
        check(ri == 1, "R5 high part entered", ri, 1);
        check(cnt == 0, "R5 no new period", cnt, 0);

        // ---- R5/R4: request while line held low by another device ----
        slave_hold = 1'b1;
        run_req = 1'b1;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (scl_drive_low) bad++;
        end
        check(bad == 0, "R5 no start while line low", bad, 0);
        slave_hold = 1'b0;
        measure(0, lo_n, hi_n, mli, mhi, ri, per);
        check(per == 8, "R5 start once line high", per, 8);

        // ---- R9: freeze during low part ----
        while (stb_fall !== 1'b1) @(negedge clk);
        ce_off = 1'b1;
        repeat (2) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            if (!scl_drive_low || stb_fall || stb_rise || stb_mid_low || stb_mid_high) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R9 frozen while disabled", bad, 0);
        ce_off = 1'b0;

        // ---- R9: alternating enable doubles the period ----
        ce_alt = 1'b1;
        @(negedge clk);
        measure(0, lo_n, hi_n, mli, mhi, ri, per);
        measure(0, lo_n, hi_n, mli, mhi, ri, per);
        check(per == 16, "R9 period with half-rate enable", per, 16);
        check(lo_n == 6, "R9 low length with half-rate enable", lo_n, 6);
        ce_alt = 1'b0;

        // ---- R1: reset in the middle of a low part ----
        while (scl_drive_low !== 1'b1) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(scl_drive_low == 1'b0, "R1 reset releases line", scl_drive_low, 0);
        rst = 1'b0;
        run_req = 1'b0;
        repeat (3) @(negedge clk);
        check(scl_drive_low == 1'b0 && stb_rise == 1'b0, "R1 stays released", scl_drive_low, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule